// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block sits between one processor and a shared snooping bus and keeps a small direct-mapped, write-back cache coherent with its peers. Each line is invalid, shared or modified, and each line holds one data word, so a block is one word. Processor reads and writes use a valid/ready handshake. When a request cannot be served locally, the controller raises a bus request. Once it is granted, it issues exactly one command: fetch for reading, fetch for ownership, invalidate, or write-back of a dirty victim.

The controller watches every command that other caches place on the bus and updates its own copy in the cycle the command appears. If another cache misses on a block that this cache holds modified, this cache drives the block one cycle later and raises an abort. Memory captures the driven word instead of answering from its own copy. Writes to a block are ordered only by the order in which caches win the bus.

Top module: `snoop_inv_ctrl`

## Requirements
- R1: Reset leaves every line invalid, with bus request, command, ready, supply and abort all low; the first access to any address after a reset is a miss.
- R2: A read of an absent line issues command 1 (read miss) with the word address, returns the fill word on the data port and leaves the line shared, so a repeat read hits with no bus command.
- R3: A write to a shared line issues command 3 (invalidate) with the word address and leaves the line modified.
- R4: A write to a modified line issues no bus command, and a later read by the same processor returns the last value written.
- R5: A write to an absent line issues command 2 (write miss), merges the write data into the filled line and leaves it modified without updating memory.
- R6: A snooped read miss (command 1) that hits a modified line drives that word with supply and abort high for one cycle, one cycle after the snooped command, and leaves the line shared.
- R7: A snooped write miss (2) or invalidate (3) that hits a line makes it invalid; if the line was modified, the word is first supplied with abort, as in R6.
- R8: A snooped command whose tag does not match, or that hits an invalid line, or a snooped read miss on a shared line, produces no supply and changes no line.
- R9: Replacing a modified line issues command 4 (write-back) carrying the old address and data before the miss command for the new address; a shared victim is dropped with no write-back.
- R10: Snooped commands are applied while the processor side is stalled waiting for a grant, and the command issued at the grant reflects the updated line (a shared line invalidated while waiting turns a planned invalidate into a write miss).
- R11: The bus request stays high until a grant, each grant is followed the next cycle by exactly one one-cycle command, and the request drops after it unless a write-back must be followed by a miss.
- R12: Ready is a one-cycle pulse per request, and a new request is taken only while the controller is idle and not pulsing ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid_i | input | 1 | Processor request present; held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready on reads |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| bus_cmd_o | output | 3 | Issued command: 0 none, 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| bus_addr_o | output | ADDR_W | Block address of the issued command |
| bus_data_o | output | DATA_W | Data for a write-back |
| fill_valid_i | input | 1 | Fill word present for an outstanding miss |
| fill_data_i | input | DATA_W | Fill word |
| snp_cmd_i | input | 3 | Command observed from another cache (same encoding) |
| snp_addr_i | input | ADDR_W | Block address of the observed command |
| snp_supply_o | output | 1 | This cache drives the requested word |
| snp_data_o | output | DATA_W | Supplied word, valid with supply |
| mem_abort_o | output | 1 | Tells memory to cancel its own reply and store the supplied word |

## Verification
The table walks one line through every state pair. It starts with a read-miss fill and a shared hit, then moves through the shared-to-modified upgrade, silent modified writes, and own-write read-back. Snooped read, write-miss and invalidate commands are applied to modified, shared and invalid copies. Comparing the issued command against supply and abort separates each transition from its neighbours: an upgrade issuing 3 instead of 2 shows the line was shared, not invalid. A second line checks replacement of a modified victim against a shared one, and a tag-mismatch snoop shows that the index alone does not trigger a response. Directed cases then inject an invalidate while a write is stalled before its grant, and check that a mid-run reset empties the cache.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } line_st_t;

  typedef enum logic [2:0] {
    BC_NONE   = 3'd0,
    BC_RDMISS = 3'd1,
    BC_WRMISS = 3'd2,
    BC_INV    = 3'd3,
    BC_WBACK  = 3'd4
  } bus_cmd_t;
endpackage

// File: rtl/snp_line_store.sv
module snp_line_store
  import snp_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  c_idx_i,
  input  logic              c_we_tag_i,
  input  logic [TAG_W-1:0]  c_tag_i,
  input  logic              c_we_st_i,
  input  line_st_t          c_st_i,
  input  logic              c_we_dat_i,
  input  logic [DATA_W-1:0] c_dat_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  input  logic              s_we_i,
  input  line_st_t          s_st_i,
  output logic [TAG_W-1:0]  a_tag_o,
  output line_st_t          a_st_o,
  output logic [DATA_W-1:0] a_dat_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output line_st_t          b_st_o,
  output logic [DATA_W-1:0] b_dat_o
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] mem   [LINES];

  // state and tag: snoop port first, processor port overrides on the same line
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LN_I;
        tag_q[i] <= '0;
      end
    end else begin
      if (s_we_i)     st_q[s_idx_i]  <= s_st_i;
      if (c_we_st_i)  st_q[c_idx_i]  <= c_st_i;
      if (c_we_tag_i) tag_q[c_idx_i] <= c_tag_i;
    end
  end

  // data array: one write port, two registered read ports
  always_ff @(posedge clk) begin
    if (c_we_dat_i) mem[c_idx_i] <= c_dat_i;
    a_dat_o <= mem[c_idx_i];
    b_dat_o <= mem[s_idx_i];
  end

  assign a_tag_o = tag_q[c_idx_i];
  assign a_st_o  = st_q[c_idx_i];
  assign b_tag_o = tag_q[s_idx_i];
  assign b_st_o  = st_q[s_idx_i];
endmodule

// File: rtl/snp_snoop_unit.sv
module snp_snoop_unit
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [TAG_W-1:0]  b_tag_i,
  input  line_st_t          b_st_i,
  output logic [IDX_W-1:0]  s_idx_o,
  output logic              s_we_o,
  output line_st_t          s_st_o,
  output logic              supply_o,
  output logic              abort_o
);
  logic line_hit;
  logic sup_d;

  assign s_idx_o  = snp_addr_i[IDX_W-1:0];
  assign line_hit = (b_st_i != LN_I) && (b_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);

  always_comb begin
    s_we_o = 1'b0;
    s_st_o = b_st_i;
    sup_d  = 1'b0;
    case (bus_cmd_t'(snp_cmd_i))
      BC_RDMISS: if (line_hit && b_st_i == LN_M) begin
        s_we_o = 1'b1;
        s_st_o = LN_S;
        sup_d  = 1'b1;
      end
      BC_WRMISS, BC_INV: if (line_hit) begin
        s_we_o = 1'b1;
        s_st_o = LN_I;
        sup_d  = (b_st_i == LN_M);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      supply_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      supply_o <= sup_d;
      abort_o  <= sup_d;
    end
  end

  // R6/R7: a supply only ever answers a snooped miss or invalidate
  a_r6_supply_follows_snoop: assert property (@(posedge clk) disable iff (rst)
    supply_o |-> $past(snp_cmd_i == BC_RDMISS || snp_cmd_i == BC_WRMISS || snp_cmd_i == BC_INV));
endmodule

// File: rtl/snp_cpu_fsm.sv
module snp_cpu_fsm
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  line_st_t          a_st_i,
  input  logic [DATA_W-1:0] a_dat_i,
  input  logic              s_we_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  input  line_st_t          s_st_i,
  output logic [IDX_W-1:0]  c_idx_o,
  output logic              c_we_tag_o,
  output logic [TAG_W-1:0]  c_tag_o,
  output logic              c_we_st_o,
  output line_st_t          c_st_o,
  output logic              c_we_dat_o,
  output logic [DATA_W-1:0] c_dat_o
);
  typedef enum logic [1:0] {F_IDLE, F_LOOK, F_REQ, F_FILL} fsm_t;

  fsm_t              fs_q, fs_d;
  logic              rq_we_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [DATA_W-1:0] rq_wdata_q;
  logic [IDX_W-1:0]  rq_idx;
  logic [TAG_W-1:0]  rq_tag;
  line_st_t          eff_st;
  logic              tag_hit, accept, done;
  bus_cmd_t          cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d, rdata_d;

  assign rq_idx  = rq_addr_q[IDX_W-1:0];
  assign rq_tag  = rq_addr_q[ADDR_W-1:IDX_W];
  assign c_idx_o = (fs_q == F_IDLE) ? cpu_addr_i[IDX_W-1:0] : rq_idx;
  // line state as it will be after a snoop landing in this same cycle
  assign eff_st  = (s_we_i && s_idx_i == rq_idx) ? s_st_i : a_st_i;
  assign tag_hit = (a_tag_i == rq_tag) && (eff_st != LN_I);

  always_comb begin
    fs_d       = fs_q;
    accept     = 1'b0;
    done       = 1'b0;
    rdata_d    = cpu_rdata_o;
    cmd_d      = BC_NONE;
    addr_d     = rq_addr_q;
    data_d     = '0;
    c_we_tag_o = 1'b0;
    c_tag_o    = rq_tag;
    c_we_st_o  = 1'b0;
    c_st_o     = LN_I;
    c_we_dat_o = 1'b0;
    c_dat_o    = rq_wdata_q;
    case (fs_q)
      F_IDLE: if (cpu_valid_i && !cpu_ready_o) begin
        accept = 1'b1;
        fs_d   = F_LOOK;
      end
      F_LOOK: begin
        if (tag_hit && !rq_we_q) begin
          rdata_d = a_dat_i;
          done    = 1'b1;
          fs_d    = F_IDLE;
        end else if (tag_hit && eff_st == LN_M) begin
          c_we_dat_o = 1'b1;
          done       = 1'b1;
          fs_d       = F_IDLE;
        end else begin
          fs_d = F_REQ;
        end
      end
      F_REQ: if (bus_gnt_i) begin
        if (!tag_hit && eff_st == LN_M) begin
          cmd_d     = BC_WBACK;
          addr_d    = {a_tag_i, rq_idx};
          data_d    = a_dat_i;
          c_we_st_o = 1'b1;
          c_st_o    = LN_I;
        end else if (tag_hit && rq_we_q) begin
          cmd_d      = BC_INV;
          c_we_st_o  = 1'b1;
          c_st_o     = LN_M;
          c_we_dat_o = 1'b1;
          done       = 1'b1;
          fs_d       = F_IDLE;
        end else begin
          cmd_d = rq_we_q ? BC_WRMISS : BC_RDMISS;
          fs_d  = F_FILL;
        end
      end
      F_FILL: if (fill_valid_i) begin
        c_we_tag_o = 1'b1;
        c_we_st_o  = 1'b1;
        c_st_o     = rq_we_q ? LN_M : LN_S;
        c_we_dat_o = 1'b1;
        c_dat_o    = rq_we_q ? rq_wdata_q : fill_data_i;
        rdata_d    = fill_data_i;
        done       = 1'b1;
        fs_d       = F_IDLE;
      end
      default: fs_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q        <= F_IDLE;
      rq_we_q     <= 1'b0;
      rq_addr_q   <= '0;
      rq_wdata_q  <= '0;
      cpu_ready_o <= 1'b0;
      cpu_rdata_o <= '0;
      bus_req_o   <= 1'b0;
      bus_cmd_o   <= BC_NONE;
      bus_addr_o  <= '0;
      bus_data_o  <= '0;
    end else begin
      fs_q        <= fs_d;
      cpu_ready_o <= done;
      cpu_rdata_o <= rdata_d;
      bus_req_o   <= (fs_d == F_REQ);
      bus_cmd_o   <= cmd_d;
      bus_addr_o  <= addr_d;
      bus_data_o  <= data_d;
      if (accept) begin
        rq_we_q    <= cpu_we_i;
        rq_addr_q  <= cpu_addr_i;
        rq_wdata_q <= cpu_wdata_i;
      end
    end
  end

  a_r11_cmd_needs_grant: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd_o != BC_NONE) |-> ($past(bus_gnt_i) && $past(bus_req_o)));
  a_r11_grant_gives_cmd: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && bus_gnt_i) |=> (bus_cmd_o != BC_NONE));
  a_r9_wback_rerequests: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd_o == BC_WBACK) |-> bus_req_o);
  a_r12_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready_o |=> !cpu_ready_o);
endmodule

// File: rtl/snoop_inv_ctrl.sv
module snoop_inv_ctrl
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o,
  output logic              mem_abort_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  c_idx, s_idx;
  logic              c_we_tag, c_we_st, c_we_dat, s_we;
  logic [TAG_W-1:0]  c_tag, a_tag, b_tag;
  line_st_t          c_st, s_st, a_st, b_st;
  logic [DATA_W-1:0] c_dat, a_dat;

  snp_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .c_idx_i(c_idx), .c_we_tag_i(c_we_tag), .c_tag_i(c_tag),
    .c_we_st_i(c_we_st), .c_st_i(c_st), .c_we_dat_i(c_we_dat), .c_dat_i(c_dat),
    .s_idx_i(s_idx), .s_we_i(s_we), .s_st_i(s_st),
    .a_tag_o(a_tag), .a_st_o(a_st), .a_dat_o(a_dat),
    .b_tag_o(b_tag), .b_st_o(b_st), .b_dat_o(snp_data_o)
  );

  snp_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_cmd_i(snp_cmd_i), .snp_addr_i(snp_addr_i),
    .b_tag_i(b_tag), .b_st_i(b_st),
    .s_idx_o(s_idx), .s_we_o(s_we), .s_st_o(s_st),
    .supply_o(snp_supply_o), .abort_o(mem_abort_o)
  );

  snp_cpu_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_valid_i(cpu_valid_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_cmd_o(bus_cmd_o),
    .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
    .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i),
    .a_tag_i(a_tag), .a_st_i(a_st), .a_dat_i(a_dat),
    .s_we_i(s_we), .s_idx_i(s_idx), .s_st_i(s_st),
    .c_idx_o(c_idx), .c_we_tag_o(c_we_tag), .c_tag_o(c_tag),
    .c_we_st_o(c_we_st), .c_st_o(c_st), .c_we_dat_o(c_we_dat), .c_dat_o(c_dat)
  );
endmodule

// File: tb/snoop_inv_ctrl_test.sv
`timescale 1ns/1ps
module snoop_inv_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        bus_req, bus_gnt = 1'b0;
  logic [2:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_data;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_data = '0;
  logic [2:0]  snp_cmd = '0;
  logic [7:0]  snp_addr = '0;
  logic        snp_supply, mem_abort;
  logic [15:0] snp_data;

  logic [15:0] mem [256];
  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  always #10 clk = ~clk;  // 50 MHz

  snoop_inv_ctrl uut (
    .clk(clk), .rst(rst),
    .cpu_valid_i(cpu_valid), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
    .bus_addr_o(bus_addr), .bus_data_o(bus_data),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_supply_o(snp_supply), .snp_data_o(snp_data), .mem_abort_o(mem_abort)
  );

  // kind(2) addr(8) data(16) cmd0(3) cmd1(3) val(16) sup(1); kind 0 read, 1 write, 2 snoop (cmd in data)
  function automatic logic [48:0] v(input logic [1:0] k, input logic [7:0] a, input logic [15:0] d,
                                    input logic [2:0] c0, input logic [2:0] c1,
                                    input logic [15:0] val, input logic s);
    return {k, a, d, c0, c1, val, s};
  endfunction

  localparam int NV = 18;
  localparam logic [48:0] VEC [NV] = '{
    v(0, 8'h04, 16'h0000, 1, 0, 16'h0404, 0),  // R1 R2 first read misses
    v(0, 8'h04, 16'h0000, 0, 0, 16'h0404, 0),  // R2 shared hit
    v(1, 8'h04, 16'hAAAA, 3, 0, 16'h0000, 0),  // R3 upgrade
    v(1, 8'h04, 16'hBBBB, 0, 0, 16'h0000, 0),  // R4 silent write
    v(0, 8'h04, 16'h0000, 0, 0, 16'hBBBB, 0),  // R4 own read-back
    v(2, 8'h04, 16'h0001, 0, 0, 16'hBBBB, 1),  // R6 snooped read miss on M
    v(1, 8'h04, 16'hCCCC, 3, 0, 16'h0000, 0),  // R6 line now shared
    v(2, 8'h04, 16'h0003, 0, 0, 16'hCCCC, 1),  // R7 invalidate on M
    v(0, 8'h04, 16'h0000, 1, 0, 16'hCCCC, 0),  // R7 line now invalid
    v(2, 8'h04, 16'h0002, 0, 0, 16'h0000, 0),  // R7 write miss on S
    v(2, 8'h04, 16'h0001, 0, 0, 16'h0000, 0),  // R8 snoop on invalid line
    v(0, 8'h04, 16'h0000, 1, 0, 16'hCCCC, 0),  // R7 invalid after write miss
    v(1, 8'h09, 16'h1111, 2, 0, 16'h0000, 0),  // R5 write miss
    v(0, 8'h05, 16'h0000, 4, 1, 16'h0505, 0),  // R9 dirty victim written back
    v(0, 8'h09, 16'h0000, 1, 0, 16'h1111, 0),  // R9 shared victim dropped
    v(2, 8'h0D, 16'h0001, 0, 0, 16'h0000, 0),  // R8 tag mismatch
    v(2, 8'h09, 16'h0001, 0, 0, 16'h0000, 0),  // R8 read miss on shared
    v(0, 8'h09, 16'h0000, 0, 0, 16'h1111, 0)   // R8 line unchanged
  };
  localparam int RQ [NV] = '{2, 2, 3, 4, 4, 6, 6, 7, 7, 7, 8, 7, 5, 9, 9, 8, 8, 8};

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] d,
                        output logic [2:0] c0, output logic [2:0] c1, output logic [15:0] rd);
    int nc = 0;
    c0 = 0; c1 = 0; rd = 0;
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      bus_gnt = 0; fill_valid = 0;
      if (bus_cmd != 0) begin
        if (nc == 0) c0 = bus_cmd; else c1 = bus_cmd;
        nc++;
        if (bus_cmd == 3'd4) mem[bus_addr] = bus_data;
        else if (bus_cmd == 3'd1 || bus_cmd == 3'd2) begin
          fill_valid = 1; fill_data = mem[bus_addr];
        end
      end
      if (bus_req) bus_gnt = 1;
      if (cpu_ready) begin
        rd = cpu_rdata; cpu_valid = 0;
        break;
      end
    end
    @(negedge clk);
    chk(cpu_ready == 0, "R12 ready pulse", {15'd0, cpu_ready}, 16'd0);
  endtask

  task automatic snoop_op(input logic [2:0] c, input logic [7:0] a,
                          output logic s, output logic ab, output logic [15:0] dat);
    @(negedge clk);
    snp_cmd = c; snp_addr = a;
    @(negedge clk);
    s = snp_supply; ab = mem_abort; dat = snp_data;
    snp_cmd = 0;
    if (s) mem[a] = dat;
  endtask

  initial begin
    logic [2:0] c0, c1;
    logic [15:0] rd;
    logic s, ab;
    for (int i = 0; i < 256; i++) mem[i] = {i[7:0], i[7:0]};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(bus_req == 0 && bus_cmd == 0, "R1 bus idle", {13'd0, bus_cmd}, 16'd0);
    chk(cpu_ready == 0, "R1 ready low", {15'd0, cpu_ready}, 16'd0);
    chk(snp_supply == 0 && mem_abort == 0, "R1 supply low", {15'd0, snp_supply}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [48:0] e;
      string tg;
      e = VEC[i];
      tg = $sformatf("R%0d vec %0d", RQ[i], i);
      if (e[48:47] == 2'd2) begin
        snoop_op(e[25:23], e[46:39], s, ab, rd);
        chk(s == e[0], {tg, " supply"}, {15'd0, s}, {15'd0, e[0]});
        chk(ab == e[0], {tg, " abort"}, {15'd0, ab}, {15'd0, e[0]});
        if (e[0]) chk(rd == e[16:1], {tg, " supplied data"}, rd, e[16:1]);
      end else begin
        cpu_op(e[47], e[46:39], e[38:23], c0, c1, rd);
        chk(c0 == e[22:20], {tg, " first cmd"}, {13'd0, c0}, {13'd0, e[22:20]});
        chk(c1 == e[19:17], {tg, " second cmd"}, {13'd0, c1}, {13'd0, e[19:17]});
        if (e[48:47] == 2'd0) chk(rd == e[16:1], {tg, " read data"}, rd, e[16:1]);
      end
    end

    // R10: invalidate lands while a write to a shared line waits for grant
    @(negedge clk);
    cpu_valid = 1; cpu_we = 1; cpu_addr = 8'h09; cpu_wdata = 16'h2222;
    @(negedge clk);
    @(negedge clk);
    chk(bus_req == 1, "R11 request raised", {15'd0, bus_req}, 16'd1);
    snp_cmd = 3'd3; snp_addr = 8'h09;
    @(negedge clk);
    snp_cmd = 0;
    chk(bus_req == 1, "R11 request held", {15'd0, bus_req}, 16'd1);
    chk(snp_supply == 0, "R10 no supply from shared", {15'd0, snp_supply}, 16'd0);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(bus_cmd == 3'd2, "R10 write miss after stall", {13'd0, bus_cmd}, 16'd2);
    chk(bus_addr == 8'h09, "R10 command address", {8'd0, bus_addr}, 16'h0009);
    chk(bus_req == 0, "R11 request dropped", {15'd0, bus_req}, 16'd0);
    fill_valid = 1; fill_data = mem[8'h09];
    @(negedge clk);
    fill_valid = 0;
    chk(cpu_ready == 1, "R12 ready after fill", {15'd0, cpu_ready}, 16'd1);
    cpu_valid = 0;
    cpu_op(0, 8'h09, 16'h0, c0, c1, rd);
    chk(c0 == 0, "R10 hit after stalled write", {13'd0, c0}, 16'd0);
    chk(rd == 16'h2222, "R10 read-back", rd, 16'h2222);

    // R1: reset mid-run empties the cache
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    cpu_op(0, 8'h09, 16'h0, c0, c1, rd);
    chk(c0 == 3'd1, "R1 miss after reset", {13'd0, c0}, 16'd1);

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule